// File: doc/BRIEF.md
# Lazy Tile-State Usage Tracker

This block keeps, for each hardware thread, two bits of control state for a large matrix tile register file: whether the tile feature has been switched on for that thread, and whether the thread has touched its tiles since they were last in the all-zero initial state. The first tile instruction a thread issues while its feature is off does not execute. Instead it raises a device-not-available fault, so that a handler can set up the thread's save area. After the handler turns the feature on, the re-issued instruction is accepted.

Context-switch logic asks, for the outgoing thread, whether its tile state must be written out. Saving the eight 1 KB tile registers costs 8 KB per context. A thread whose tiles are still in the zeroed initial state is therefore skipped: the tracker flags a save only for threads that have actually run a tile instruction. A release command returns a thread's tiles to the initial state and keeps its feature enabled.

All outputs are registered and respond in the cycle after the request. Every command applies to the thread named on `threadId` in that cycle.

Top module: `tile_track`

## Requirements
- R1: After reset, every thread's enable bit and in-use bit are clear, and `issueAccept`, `faultPulse` and `saveRequired` are all low.
- R2: A tile issue from a thread whose enable bit is clear raises `faultPulse` for exactly one cycle, the cycle after the issue, with `issueAccept` low.
- R3: A faulting issue is precise: it does not set the thread's in-use bit, so a later switch request for that thread gives `saveRequired` low.
- R4: `enableCmd` sets the enable bit of the named thread. A later issue from that thread raises `issueAccept` for one cycle, the cycle after the issue, with `faultPulse` low.
- R5: An accepted issue sets the in-use bit of the issuing thread.
- R6: In the cycle after a switch request, `saveRequired` equals the named thread's in-use bit as it stood before that cycle's updates. In any cycle that does not follow a switch request, `saveRequired` is low.
- R7: `releaseCmd` clears the named thread's in-use bit and leaves its enable bit set, so the next issue from that thread is accepted without a fault.
- R8: Each thread's bits are independent. A command for one thread does not change what any other thread sees, and this holds up to the highest thread index.
- R9: Same-cycle ordering. An issue is judged against the enable bit as it stood before that cycle's `enableCmd`, so an issue together with an enable faults while the enable still takes effect. A release together with an accepted issue leaves the in-use bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadId | input | TID_W (3) | Thread that all commands in this cycle apply to |
| issueValid | input | 1 | A tile instruction is issued by the thread |
| enableCmd | input | 1 | Handler turns the tile feature on for the thread |
| releaseCmd | input | 1 | Return the thread's tiles to the initial state |
| switchReq | input | 1 | Context switch away from the thread |
| issueAccept | output | 1 | Issue accepted (one cycle, one cycle after the issue) |
| faultPulse | output | 1 | Device-not-available fault (one cycle, one cycle after the issue) |
| saveRequired | output | 1 | Outgoing thread's tile state must be saved |

## Verification
The bench targets the first-use trap: a design that let the faulting instruction mark the thread in use would request a needless 8 KB save on the next switch. It drives an issue and an enable in the same cycle, where a design that forwards the fresh enable bit would accept an issue that should fault. It drives a release and a switch request against threads with tiles in use, where a design that cleared the enable bit would fault again after the release, or would sample in-use after the update and report the wrong save decision. It also exercises threads 0 and 7, so that an index decode that mixes up neighbouring threads shows up as a cross-thread effect.

// File: rtl/tile_track_pkg.sv
package tile_track_pkg;

  // Strobes from the control to the per-thread state registers
  typedef struct packed {
    logic setEnable;
    logic setInUse;
    logic clrInUse;
  } tileStrobe_t;

endpackage

// File: rtl/tile_track_state.sv
module tile_track_state
  import tile_track_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int TID_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TID_W-1:0]       threadId,
  input  tileStrobe_t            strobe,
  output logic [NUM_THREADS-1:0] enableVec,
  output logic [NUM_THREADS-1:0] inUseVec
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    logic hit;
    assign hit = (threadId == TID_W'(t));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enableVec[t] <= 1'b0;
        inUseVec[t]  <= 1'b0;
      end else if (hit) begin
        if (strobe.setEnable) enableVec[t] <= 1'b1;
        // release wins over a same-cycle accepted issue
        if (strobe.clrInUse)      inUseVec[t] <= 1'b0;
        else if (strobe.setInUse) inUseVec[t] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tile_track_ctrl.sv
module tile_track_ctrl
  import tile_track_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int TID_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TID_W-1:0]       threadId,
  input  logic                   issueValid,
  input  logic                   enableCmd,
  input  logic                   releaseCmd,
  input  logic                   switchReq,
  input  logic [NUM_THREADS-1:0] enableVec,
  input  logic [NUM_THREADS-1:0] inUseVec,
  output tileStrobe_t            strobe,
  output logic                   issueAccept,
  output logic                   faultPulse,
  output logic                   saveRequired
);

  localparam int SLOTS = 1 << TID_W;

  logic [SLOTS-1:0] enExt;
  logic [SLOTS-1:0] useExt;
  logic             tidOk;
  logic             curEn;
  logic             curUse;
  logic             acceptNext;
  logic             faultNext;
  logic             saveNext;

  assign enExt  = SLOTS'(enableVec);
  assign useExt = SLOTS'(inUseVec);
  assign tidOk  = (32'(threadId) < NUM_THREADS);
  assign curEn  = enExt[threadId];
  assign curUse = useExt[threadId];

  // judged against state before this cycle's commands
  assign acceptNext = issueValid & tidOk & curEn;
  assign faultNext  = issueValid & tidOk & ~curEn;
  assign saveNext   = switchReq & tidOk & curUse;

  always_comb begin
    strobe           = '0;
    strobe.setEnable = enableCmd;
    strobe.setInUse  = acceptNext;
    strobe.clrInUse  = releaseCmd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueAccept  <= 1'b0;
      faultPulse   <= 1'b0;
      saveRequired <= 1'b0;
    end else begin
      issueAccept  <= acceptNext;
      faultPulse   <= faultNext;
      saveRequired <= saveNext;
    end
  end

endmodule

// File: rtl/tile_track.sv
module tile_track
  import tile_track_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TID_W-1:0] threadId,
  input  logic             issueValid,
  input  logic             enableCmd,
  input  logic             releaseCmd,
  input  logic             switchReq,
  output logic             issueAccept,
  output logic             faultPulse,
  output logic             saveRequired
);

  tileStrobe_t            strobe;
  logic [NUM_THREADS-1:0] enableVec;
  logic [NUM_THREADS-1:0] inUseVec;

  tile_track_ctrl #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .threadId    (threadId),
    .issueValid  (issueValid),
    .enableCmd   (enableCmd),
    .releaseCmd  (releaseCmd),
    .switchReq   (switchReq),
    .enableVec   (enableVec),
    .inUseVec    (inUseVec),
    .strobe      (strobe),
    .issueAccept (issueAccept),
    .faultPulse  (faultPulse),
    .saveRequired(saveRequired)
  );

  tile_track_state #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_state (
    .clk      (clk),
    .rstN     (rstN),
    .threadId (threadId),
    .strobe   (strobe),
    .enableVec(enableVec),
    .inUseVec (inUseVec)
  );

endmodule

// File: rtl/tile_track_chk.sv
module tile_track_chk #(
  parameter int NUM_THREADS = 8,
  parameter int TID_W       = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [TID_W-1:0]       threadId,
  input logic                   issueValid,
  input logic                   enableCmd,
  input logic                   releaseCmd,
  input logic                   switchReq,
  input logic                   issueAccept,
  input logic                   faultPulse,
  input logic                   saveRequired,
  input logic [NUM_THREADS-1:0] enableVec,
  input logic [NUM_THREADS-1:0] inUseVec
);

  localparam int SLOTS = 1 << TID_W;

  logic [SLOTS-1:0] enX;
  logic [SLOTS-1:0] useX;
  assign enX  = SLOTS'(enableVec);
  assign useX = SLOTS'(inUseVec);

  AST_ACCEPT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(issueAccept && faultPulse)); // R2

  AST_FAULT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !enX[threadId]) |=> (faultPulse && !issueAccept)); // R2

  AST_FAULT_PRECISE: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !enX[threadId] && !releaseCmd) |=> (inUseVec == $past(inUseVec))); // R3

  AST_ACCEPT_WHEN_ON: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && enX[threadId]) |=> (issueAccept && !faultPulse)); // R4

  AST_SAVE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    switchReq |=> (saveRequired == $past(useX[threadId]))); // R6

  AST_SAVE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !switchReq |=> !saveRequired); // R6

  AST_RELEASE_KEEPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    releaseCmd |=> (enableVec == $past(enableVec) || enableCmd || $past(enableCmd))); // R7

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (releaseCmd && 32'(threadId) < NUM_THREADS) |=> (useX[$past(threadId)] == 1'b0)); // R9

endmodule

bind tile_track tile_track_chk #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_chk (.*);

// File: tb/tile_track_bench.sv
`timescale 1ns/1ps
module tile_track_bench;

  typedef struct {
    logic  acc;
    logic  flt;
    logic  sav;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] threadId = '0;
  logic       issueValid = 1'b0;
  logic       enableCmd = 1'b0;
  logic       releaseCmd = 1'b0;
  logic       switchReq = 1'b0;
  logic       issueAccept;
  logic       faultPulse;
  logic       saveRequired;

  int       nChecks = 0;
  int       nFails = 0;
  bit       done = 1'b0;
  bit       armed = 1'b0;
  expItem_t expQ[$];
  bit       mEn[8];
  bit       mUse[8];

  always #2 clk = ~clk;

  tile_track u_tile_track (
    .clk(clk), .rstN(rstN), .threadId(threadId), .issueValid(issueValid),
    .enableCmd(enableCmd), .releaseCmd(releaseCmd), .switchReq(switchReq),
    .issueAccept(issueAccept), .faultPulse(faultPulse), .saveRequired(saveRequired)
  );

  // driver: one cycle of stimulus, expectation from the requirement model
  task automatic step(input int tid, input bit iss, input bit en, input bit rel,
                      input bit sw, input string tag);
    expItem_t e;
    @(negedge clk);
    e.acc = iss & mEn[tid];
    e.flt = iss & ~mEn[tid];
    e.sav = sw & mUse[tid];
    e.tag = tag;
    if (en) mEn[tid] = 1'b1;
    if (rel) mUse[tid] = 1'b0;
    else if (e.acc) mUse[tid] = 1'b1;
    expQ.push_back(e);
    threadId   = 3'(tid);
    issueValid = iss;
    enableCmd  = en;
    releaseCmd = rel;
    switchReq  = sw;
  endtask

  // monitor: compare results one cycle after each driven cycle
  always @(posedge clk) begin
    if (armed && expQ.size() > 0) begin
      expItem_t e;
      #1;
      e = expQ.pop_front();
      nChecks++;
      if ({issueAccept, faultPulse, saveRequired} !== {e.acc, e.flt, e.sav}) begin
        nFails++;
        $display("FAIL %s: acc/flt/sav actual %b%b%b expected %b%b%b", e.tag,
                 issueAccept, faultPulse, saveRequired, e.acc, e.flt, e.sav);
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mEn[i] = 1'b0; mUse[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if ({issueAccept, faultPulse, saveRequired} !== 3'b000) begin
      nFails++;
      $display("FAIL R1: outputs in reset actual %b%b%b expected 000",
               issueAccept, faultPulse, saveRequired);
    end
    rstN = 1'b1;
    armed = 1'b1;
    step(0, 0, 0, 0, 1, "R1");   // no thread in use after reset
    step(5, 0, 0, 0, 1, "R1");
    step(3, 1, 0, 0, 0, "R2");   // first use traps
    step(3, 0, 0, 0, 0, "R2");   // pulse lasts one cycle
    step(3, 0, 0, 0, 1, "R3");   // trap left tiles initial
    step(3, 0, 1, 0, 0, "R4");   // handler enables
    step(3, 1, 0, 0, 0, "R4");   // re-issue accepted
    step(3, 0, 0, 0, 1, "R5");   // now in use: save
    step(3, 0, 0, 0, 0, "R6");   // no request: low
    step(4, 0, 0, 0, 1, "R8");   // other thread untouched
    step(4, 1, 0, 0, 0, "R8");   // other thread still traps
    step(3, 0, 0, 1, 0, "R7");   // release
    step(3, 0, 0, 0, 1, "R7");   // back to initial
    step(3, 1, 0, 0, 0, "R7");   // enable kept: accepted
    step(3, 1, 0, 1, 0, "R9");   // issue + release
    step(3, 0, 0, 0, 1, "R9");   // release won
    step(6, 1, 1, 0, 0, "R9");   // issue + enable faults
    step(6, 1, 0, 0, 0, "R9");   // enable took effect
    step(0, 0, 1, 0, 0, "R4");
    step(0, 1, 0, 0, 1, "R6");   // switch sees pre-issue state
    step(0, 0, 0, 0, 1, "R6");
    step(7, 0, 1, 0, 0, "R8");
    step(7, 1, 0, 0, 0, "R8");
    step(7, 0, 0, 0, 1, "R8");
    step(6, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule